// File: doc/BRIEF.md
# Four-Channel Boundary-Synchronised PWM Generator

This block produces four independent pulse-width-modulated outputs, each controlled through a small window of registers on a simple single-cycle register bus. A channel counts input clock cycles through a clock divider and then through a period counter. Its output is high for the leading part of every period and low for the rest.

Software stages a new divider, period length and high time in staging registers. Writing the high-time register requests a change. The running channel adopts all three staged values together, but only when its current period has run to the end. A waveform period therefore never mixes the old and new settings. Switching a channel off acts at once, with no wait for the period to end. Switching it on loads whatever is staged and starts counting from zero.

The register map gives each channel a 32-byte window, placed at the channel index times 32. Inside a window there are four registers: the divider, the period length, the high time and the run control. All other addresses read as zero and ignore writes.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register of every channel reads 0 and all four outputs are low.
- R2: Channel c owns byte addresses c*32 plus an offset. The offsets are: 0x00 for the 8-bit divider, 0x04 for the 8-bit period length, 0x08 for the 16-bit high time and 0x18 for the run control, whose bit 0 runs the channel. A read returns the stored field, with every bit above the field read as 0.
- R3: Any offset other than those four, and any address at or above 0x80, reads as 0. A write to such an address changes no register.
- R4: With divider D, period length M and high time H, the output repeats every (D+1)*M cycles. It is high for the first (D+1)*H cycles of each period and low for the rest. The first period starts in the cycle right after the run bit is written to 1.
- R5: A high time of M or more keeps the output high for the whole period. A high time of 0 keeps it low. A period length of 0 keeps the output low while the channel runs.
- R6: Writing the divider or the period length of a running channel, with no high-time write after it, leaves the output waveform unchanged.
- R7: A high-time write arms a change. The staged divider, period length and high time take effect together at the first period end that comes at least one full cycle after the write. A write made in the last cycle of a period therefore waits for the following period end.
- R8: Writing 0 to the run bit drives the output low from the next cycle on, even in the middle of a period. A stopped channel always drives its output low.
- R9: Writing 1 to the run bit of a stopped channel loads the staged values at once, whether or not a change was armed. Writing 1 to a channel that is already running does not restart it.
- R10: Each channel runs from its own registers and counters, so activity on one channel does not change the waveform of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counting reference for all channels |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe; the write happens at the next rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| pwm_out | output | 4 | One waveform output per channel, bit c for channel c |

## Verification
The assertions assume one bus access per cycle and a write strobe that is never unknown once reset has been released. They also assume that the run bit is the only path that starts a channel. The bench drives the bus only on falling clock edges and never issues two accesses in the same cycle. It waits until all staged writes for a channel are finished before it judges that channel's waveform, so each waveform check only sees settings that were legally committed.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;

   // Register selection decoded from the in-window byte offset.
   typedef enum logic [2:0] {
      RSEL_NONE = 3'd0,
      RSEL_DIV  = 3'd1,
      RSEL_LEN  = 3'd2,
      RSEL_HIGH = 3'd3,
      RSEL_RUN  = 3'd4
   } rsel_e;

   // In-window byte offsets; software and the bench depend on these values.
   localparam int unsigned OFS_DIV  = 32'h00;
   localparam int unsigned OFS_LEN  = 32'h04;
   localparam int unsigned OFS_HIGH = 32'h08;
   localparam int unsigned OFS_RUN  = 32'h18;

endpackage

// File: rtl/pwmb_decode.sv
module pwmb_decode
   import pwmb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned N_CH      = 4,
   parameter int unsigned STRIDE_LG = 5,
   parameter int unsigned CH_W      = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [CH_W-1:0]   ch,
   output rsel_e             sel
);

   localparam int unsigned HI_LSB = STRIDE_LG + CH_W;

   logic                 upper_ok;
   logic                 ch_ok;
   logic [STRIDE_LG-1:0] ofs;

   // Address bits above the channel field must be zero, if any exist.
   generate
      if (ADDR_W > HI_LSB) begin : g_upper
         assign upper_ok = (addr[ADDR_W-1:HI_LSB] == '0);
      end else begin : g_no_upper
         assign upper_ok = 1'b1;
      end
   endgenerate

   assign ch    = addr[HI_LSB-1:STRIDE_LG];
   assign ofs   = addr[STRIDE_LG-1:0];
   assign ch_ok = (int'(ch) < int'(N_CH));

   always_comb begin
      sel = RSEL_NONE;
      if (upper_ok && ch_ok) begin
         if (ofs == STRIDE_LG'(OFS_DIV))       sel = RSEL_DIV;
         else if (ofs == STRIDE_LG'(OFS_LEN))  sel = RSEL_LEN;
         else if (ofs == STRIDE_LG'(OFS_HIGH)) sel = RSEL_HIGH;
         else if (ofs == STRIDE_LG'(OFS_RUN))  sel = RSEL_RUN;
         else                                  sel = RSEL_NONE;
      end
   end

endmodule

// File: rtl/pwmb_stage.sv
module pwmb_stage
   import pwmb_pkg::*;
#(
   parameter int unsigned DIV_W  = 8,
   parameter int unsigned LEN_W  = 8,
   parameter int unsigned HIGH_W = 16,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  rsel_e             sel,
   input  logic [HIGH_W-1:0] wval,
   input  logic              taken,
   output logic [DIV_W-1:0]  st_div,
   output logic [LEN_W-1:0]  st_len,
   output logic [HIGH_W-1:0] st_high,
   output logic              run,
   output logic              armed,
   output logic              start,
   output logic [DATA_W-1:0] rd_word
);

   logic wr_high;

   assign wr_high = wr && (sel == RSEL_HIGH);
   assign start   = wr && (sel == RSEL_RUN) && wval[0] && !run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_div  <= '0;
         st_len  <= '0;
         st_high <= '0;
         run     <= 1'b0;
      end else if (wr) begin
         case (sel)
            RSEL_DIV:  st_div  <= wval[DIV_W-1:0];
            RSEL_LEN:  st_len  <= wval[LEN_W-1:0];
            RSEL_HIGH: st_high <= wval;
            RSEL_RUN:  run     <= wval[0];
            default:   ;
         endcase
      end
   end

   // A new high-time write wins over a commit happening in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            armed <= 1'b0;
      else if (wr_high)      armed <= 1'b1;
      else if (start || taken) armed <= 1'b0;
   end

   always_comb begin
      rd_word = '0;
      case (sel)
         RSEL_DIV:  rd_word = DATA_W'(st_div);
         RSEL_LEN:  rd_word = DATA_W'(st_len);
         RSEL_HIGH: rd_word = DATA_W'(st_high);
         RSEL_RUN:  rd_word = DATA_W'(run);
         default:   rd_word = '0;
      endcase
   end

endmodule

// File: rtl/pwmb_engine.sv
module pwmb_engine #(
   parameter int unsigned DIV_W  = 8,
   parameter int unsigned LEN_W  = 8,
   parameter int unsigned HIGH_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              start,
   input  logic              armed,
   input  logic [DIV_W-1:0]  st_div,
   input  logic [LEN_W-1:0]  st_len,
   input  logic [HIGH_W-1:0] st_high,
   output logic              wave,
   output logic              taken,
   output logic [DIV_W-1:0]  act_div,
   output logic [LEN_W-1:0]  act_len,
   output logic [HIGH_W-1:0] act_high
);

   logic [DIV_W-1:0] div_cnt;
   logic [LEN_W-1:0] pos_cnt;
   logic             div_last;
   logic             pos_last;
   logic             period_end;

   assign div_last   = (div_cnt == act_div);
   assign pos_last   = (act_len == '0) || (pos_cnt == LEN_W'(act_len - 1'b1));
   assign period_end = run && div_last && pos_last;
   assign taken      = period_end && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_div  <= '0;
         act_len  <= '0;
         act_high <= '0;
         div_cnt  <= '0;
         pos_cnt  <= '0;
      end else if (start) begin
         act_div  <= st_div;
         act_len  <= st_len;
         act_high <= st_high;
         div_cnt  <= '0;
         pos_cnt  <= '0;
      end else if (!run) begin
         div_cnt  <= '0;
         pos_cnt  <= '0;
      end else if (div_last) begin
         div_cnt <= '0;
         if (pos_last) begin
            pos_cnt <= '0;
            if (armed) begin
               act_div  <= st_div;
               act_len  <= st_len;
               act_high <= st_high;
            end
         end else begin
            pos_cnt <= pos_cnt + 1'b1;
         end
      end else begin
         div_cnt <= div_cnt + 1'b1;
      end
   end

   // The position counter never reaches act_len, so a high time at or above
   // the period length keeps the output high for the full period.
   assign wave = run && (act_len != '0) && (HIGH_W'(pos_cnt) < act_high);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwmb_pkg::*;
#(
   parameter int unsigned N_CH      = 4,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned STRIDE_LG = 5,
   parameter int unsigned DIV_W     = 8,
   parameter int unsigned LEN_W     = 8,
   parameter int unsigned HIGH_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_CH-1:0]   pwm_out
);

   localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

   // Elaboration-time parameter checks.
   generate
      if (HIGH_W < LEN_W) begin : g_bad_high
         $error("pwm_bank: HIGH_W must be at least LEN_W");
      end
      if (DATA_W < HIGH_W || DATA_W < DIV_W) begin : g_bad_data
         $error("pwm_bank: DATA_W too narrow for the fields");
      end
      if (STRIDE_LG < 5) begin : g_bad_stride
         $error("pwm_bank: window must hold offset 0x18");
      end
      if (ADDR_W < STRIDE_LG + CH_W) begin : g_bad_addr
         $error("pwm_bank: ADDR_W cannot reach every channel");
      end
   endgenerate

   logic [CH_W-1:0] dec_ch;
   rsel_e           dec_sel;

   logic [N_CH-1:0][DIV_W-1:0]  st_div;
   logic [N_CH-1:0][LEN_W-1:0]  st_len;
   logic [N_CH-1:0][HIGH_W-1:0] st_high;
   logic [N_CH-1:0][DIV_W-1:0]  act_div;
   logic [N_CH-1:0][LEN_W-1:0]  act_len;
   logic [N_CH-1:0][HIGH_W-1:0] act_high;
   logic [N_CH-1:0][DATA_W-1:0] rd_word;
   logic [N_CH-1:0]             run_q;
   logic [N_CH-1:0]             armed_q;
   logic [N_CH-1:0]             start_w;
   logic [N_CH-1:0]             taken_w;
   logic [N_CH-1:0]             ch_wr;

   logic wdata_unused;
   assign wdata_unused = ^bus_wdata[DATA_W-1:HIGH_W];

   pwmb_decode #(
      .ADDR_W   (ADDR_W),
      .N_CH     (N_CH),
      .STRIDE_LG(STRIDE_LG),
      .CH_W     (CH_W)
   ) u_dec (
      .addr(bus_addr),
      .ch  (dec_ch),
      .sel (dec_sel)
   );

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         assign ch_wr[c] = bus_we && (dec_sel != RSEL_NONE) && (dec_ch == CH_W'(c));

         pwmb_stage #(
            .DIV_W (DIV_W),
            .LEN_W (LEN_W),
            .HIGH_W(HIGH_W),
            .DATA_W(DATA_W)
         ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (ch_wr[c]),
            .sel    (dec_sel),
            .wval   (bus_wdata[HIGH_W-1:0]),
            .taken  (taken_w[c]),
            .st_div (st_div[c]),
            .st_len (st_len[c]),
            .st_high(st_high[c]),
            .run    (run_q[c]),
            .armed  (armed_q[c]),
            .start  (start_w[c]),
            .rd_word(rd_word[c])
         );

         pwmb_engine #(
            .DIV_W (DIV_W),
            .LEN_W (LEN_W),
            .HIGH_W(HIGH_W)
         ) u_eng (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run_q[c]),
            .start   (start_w[c]),
            .armed   (armed_q[c]),
            .st_div  (st_div[c]),
            .st_len  (st_len[c]),
            .st_high (st_high[c]),
            .wave    (pwm_out[c]),
            .taken   (taken_w[c]),
            .act_div (act_div[c]),
            .act_len (act_len[c]),
            .act_high(act_high[c])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < N_CH; c++) begin
         if ((dec_sel != RSEL_NONE) && (dec_ch == CH_W'(c))) bus_rdata = rd_word[c];
      end
   end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
   parameter int unsigned N_CH      = 4,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned STRIDE_LG = 5,
   parameter int unsigned LEN_W     = 8,
   parameter int unsigned HIGH_W    = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic                        bus_we,
   input logic                        wdata_b0,
   input logic [DATA_W-1:0]           bus_rdata,
   input logic [N_CH-1:0]             pwm_out,
   input logic [N_CH-1:0]             run_q,
   input logic [N_CH-1:0]             armed_q,
   input logic [N_CH-1:0][LEN_W-1:0]  act_len,
   input logic [N_CH-1:0][HIGH_W-1:0] act_high
);

   logic [STRIDE_LG-1:0] ofs;
   logic                 hole;

   assign ofs  = bus_addr[STRIDE_LG-1:0];
   assign hole = (ofs != STRIDE_LG'(8'h00)) && (ofs != STRIDE_LG'(8'h04)) &&
                 (ofs != STRIDE_LG'(8'h08)) && (ofs != STRIDE_LG'(8'h18));

   // R3: unmapped offsets read as zero
   a_r3_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      hole |-> (bus_rdata == '0));

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_c
         localparam logic [ADDR_W-1:0] RUN_ADDR = ADDR_W'((c << STRIDE_LG) + 8'h18);

         // R8: a stopped channel is low
         a_r8_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
            !run_q[c] |-> !pwm_out[c]);

         // R8: clearing the run bit takes effect in the next cycle
         a_r8_stop_now: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && (bus_addr == RUN_ADDR) && !wdata_b0) |=> !pwm_out[c]);

         // R5: zero period length keeps the output low
         a_r5_len0_low: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q[c] && (act_len[c] == '0)) |-> !pwm_out[c]);

         // R7: a running channel changes settings only when a change was armed
         a_r7_commit_armed: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q[c] && $past(run_q[c]) && (act_high[c] != $past(act_high[c])))
               |-> $past(armed_q[c]));
      end
   endgenerate

endmodule

bind pwm_bank pwm_bank_chk #(
   .N_CH     (N_CH),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .STRIDE_LG(STRIDE_LG),
   .LEN_W    (LEN_W),
   .HIGH_W   (HIGH_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_we   (bus_we),
   .wdata_b0 (bus_wdata[0]),
   .bus_rdata(bus_rdata),
   .pwm_out  (pwm_out),
   .run_q    (run_q),
   .armed_q  (armed_q),
   .act_len  (act_len),
   .act_high (act_high)
);

// File: tb/pwm_bank_tb_top.sv
module pwm_bank_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int O_DIV = 'h00, O_LEN = 'h04, O_HIGH = 'h08, O_RUN = 'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_out;

   int  n_chk = 0;
   int  n_bad = 0;
   int  gstep = 0;
   bit  done = 0;
   logic [3:0] samp;
   int  en_idx [NCH];
   int  vd [NCH];
   int  vl [NCH];
   int  vh [NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   function automatic logic [7:0] ra(int ch, int ofs);
      return 8'(ch * 32 + ofs);
   endfunction

   function automatic bit pat(int k, int d, int l, int h);
      int p;
      if (l == 0) return 1'b0;
      p = (d + 1) * l;
      return ((k % p) < (d + 1) * h);
   endfunction

   function automatic bit expv(int k, int da, int la, int ha, int db, int lb, int hb,
                               int b, int mode);
      if (b < 0 || k < b) return pat(k, da, la, ha);
      if (mode == 1) return 1'b0;
      return pat(k - b, db, lb, hb);
   endfunction

   task automatic check(bit ok, string tag, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Samples the outputs, then drives one bus cycle; starts and ends at a falling edge.
   task automatic step(bit we, logic [7:0] a, logic [31:0] d);
      samp = pwm_out;
      bus_we = we; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
      gstep++;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      gstep++;
   endtask

   task automatic cfg(int ch, int d, int l, int h);
      step(1, ra(ch, O_DIV), 32'(d));
      step(1, ra(ch, O_LEN), 32'(l));
      step(1, ra(ch, O_HIGH), 32'(h));
   endtask

   // Single-channel run with up to three scheduled writes at cycle indices k0..k2.
   task automatic run_seq(int ch, int da, int la, int ha, int db, int lb, int hb,
                          int b, int mode, int n,
                          int k0, int o0, int d0, int k1, int o1, int d1,
                          int k2, int o2, int d2, string tag);
      int bad_k = -1;
      bit ba = 0, be = 0;
      step(1, ra(ch, O_RUN), 0);
      cfg(ch, da, la, ha);
      step(1, ra(ch, O_RUN), 1);
      for (int k = 0; k < n; k++) begin
         bit e;
         if (k == k0)      step(1, ra(ch, o0), 32'(d0));
         else if (k == k1) step(1, ra(ch, o1), 32'(d1));
         else if (k == k2) step(1, ra(ch, o2), 32'(d2));
         else              step(0, 8'h0c, 0);
         e = expv(k, da, la, ha, db, lb, hb, b, mode);
         if (samp[ch] !== e && bad_k < 0) begin bad_k = k; ba = samp[ch]; be = e; end
      end
      check(bad_k < 0, $sformatf("%s ch%0d cycle %0d", tag, ch, bad_k), ba, be);
   endtask

   // All channels with settings vd/vl/vh, started one cycle apart.
   task automatic run_multi(int n, string tag);
      int bad_k [NCH];
      bit ba [NCH];
      bit be [NCH];
      for (int c = 0; c < NCH; c++) step(1, ra(c, O_RUN), 0);
      for (int c = 0; c < NCH; c++) cfg(c, vd[c], vl[c], vh[c]);
      for (int c = 0; c < NCH; c++) begin
         en_idx[c] = gstep + 1;
         step(1, ra(c, O_RUN), 1);
         bad_k[c] = -1; ba[c] = 0; be[c] = 0;
      end
      for (int i = 0; i < n; i++) begin
         int idx = gstep;
         step(0, 8'h0c, 0);
         for (int c = 0; c < NCH; c++) begin
            bit e = pat(idx - en_idx[c], vd[c], vl[c], vh[c]);
            if (samp[c] !== e && bad_k[c] < 0) begin
               bad_k[c] = idx - en_idx[c]; ba[c] = samp[c]; be[c] = e;
            end
         end
      end
      for (int c = 0; c < NCH; c++)
         check(bad_k[c] < 0, $sformatf("%s R4 R10 ch%0d d=%0d l=%0d h=%0d cycle %0d",
               tag, c, vd[c], vl[c], vh[c], bad_k[c]), ba[c], be[c]);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'd20517));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(pwm_out == 4'h0, "R1 outputs after reset", pwm_out, 0);
      for (int c = 0; c < NCH; c++) begin
         logic [31:0] acc = '0;
         rd(ra(c, O_DIV), r);  acc |= r;
         rd(ra(c, O_LEN), r);  acc |= r;
         rd(ra(c, O_HIGH), r); acc |= r;
         rd(ra(c, O_RUN), r);  acc |= r;
         check(acc == 0, $sformatf("R1 ch%0d registers after reset", c), acc, 0);
      end

      // R2: field widths and read-back
      step(1, ra(2, O_DIV), 32'hffff_ffff);
      step(1, ra(2, O_LEN), 32'hffff_ffff);
      step(1, ra(2, O_HIGH), 32'hffff_ffff);
      rd(ra(2, O_DIV), r);  check(r == 32'hff, "R2 divider width", r, 32'hff);
      rd(ra(2, O_LEN), r);  check(r == 32'hff, "R2 length width", r, 32'hff);
      rd(ra(2, O_HIGH), r); check(r == 32'hffff, "R2 high-time width", r, 32'hffff);
      step(1, ra(2, O_RUN), 32'hffff_fffe);
      rd(ra(2, O_RUN), r);  check(r == 0, "R2 run bit 0 only", r, 0);
      step(1, ra(2, O_RUN), 32'h3);
      rd(ra(2, O_RUN), r);  check(r == 1, "R2 run bit readback", r, 1);
      step(1, ra(2, O_RUN), 0);

      // R3: holes and out-of-range addresses
      step(1, ra(1, 'h0c), 32'hab);
      rd(ra(1, 'h0c), r); check(r == 0, "R3 hole reads zero", r, 0);
      step(1, 8'h80, 32'h5a);
      step(1, 8'h84, 32'h33);
      rd(8'h80, r); check(r == 0, "R3 beyond channel 3 reads zero", r, 0);
      rd(ra(0, O_DIV), r); check(r == 0, "R3 alias write ignored (divider)", r, 0);
      rd(ra(0, O_LEN), r); check(r == 0, "R3 alias write ignored (length)", r, 0);
      begin
         logic [31:0] acc = '0;
         rd(ra(1, O_DIV), r); acc |= r;
         rd(ra(1, O_LEN), r); acc |= r;
         rd(ra(1, O_HIGH), r); acc |= r;
         check(acc == 0, "R3 hole write ignored", acc, 0);
      end

      // R4 R5 R10: directed mixes
      vd = '{2, 0, 1, 3}; vl = '{5, 7, 4, 0}; vh = '{2, 7, 0, 5};
      run_multi(100, "directed-A R5");
      vd = '{0, 0, 0, 255}; vl = '{1, 255, 3, 2}; vh = '{1, 300, 1, 1};
      run_multi(100, "directed-B R5");

      // R6: divider and length writes alone do not disturb the waveform
      run_seq(0, 1, 4, 1, 0, 0, 0, -1, 0, 30,
              1, O_DIV, 3, 2, O_LEN, 9, -1, 0, 0, "R6 staged without commit");
      // R7: commit at the period end after an early high-time write
      run_seq(0, 1, 4, 1, 0, 6, 3, 8, 0, 40,
              3, O_DIV, 0, 4, O_LEN, 6, 5, O_HIGH, 3, "R7 early commit");
      // R7: a high-time write in the last cycle waits for the next period end
      run_seq(0, 1, 4, 1, 0, 6, 3, 16, 0, 40,
              5, O_DIV, 0, 6, O_LEN, 6, 7, O_HIGH, 3, "R7 late commit");
      // R8: clearing the run bit in mid-period
      run_seq(0, 0, 10, 8, 0, 0, 0, 4, 1, 12,
              3, O_RUN, 0, -1, 0, 0, -1, 0, 0, "R8 immediate stop");
      // R9: start loads staged values; a repeated run write does not restart
      run_seq(0, 1, 3, 2, 0, 0, 0, -1, 0, 24,
              5, O_RUN, 1, -1, 0, 0, -1, 0, 0, "R9 start and rerun");
      step(1, ra(0, O_RUN), 0);
      rd(ra(0, O_RUN), r);
      check(pwm_out[0] == 1'b0, "R8 stopped channel low", pwm_out[0], 0);

      // R4 R5 R10: constrained random settings
      for (int v = 0; v < 10; v++) begin
         for (int c = 0; c < NCH; c++) begin
            vd[c] = int'($urandom_range(0, 3));
            vl[c] = int'($urandom_range(0, 12));
            vh[c] = int'($urandom_range(0, 15));
         end
         run_multi(100, $sformatf("random-%0d", v));
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule